// File: doc/BRIEF.md
# DMA Request Command Decoder and Queues

This block is the front end of a small DMA controller that takes transfer-request commands from an external device. Each command is a 7-bit word holding a channel identifier, a mode field and a size field. A command with a nonzero identifier adds a request to the queue of channel 1, 2 or 3. A command with a zero identifier is decoded into one of three channel-0 actions: a handshake request, a stop request that drops the channel-0 enable, or a flush of all pending work.

Each of channels 1 to 3 has a four-deep request queue. A service port hands the queued requests downstream. Queues are served in arrival order within a channel, and the lowest-numbered non-empty channel goes first.

A separate request/grant unit answers device bus requests. It raises a grant when the arbiter is idle. The grant lasts one cycle, or a programmable precharge interval when the access hits a row miss. A bus request raised again before its grant is rejected and flagged.

Top module: `dma_cmd_front`

## Requirements
- R1: A command is `cmd_i[6:5]`=identifier, `cmd_i[4:3]`=mode, `cmd_i[2:0]`=size, sampled when `cmd_valid_i` is high. A nonzero identifier pushes one request into that channel's queue, whatever the mode and size bits hold.
- R2: Each channel queue holds at most QDEPTH (default 4) requests. `q_full_o[n-1]` is high when channel n's queue is full, and a push to a full queue is dropped.
- R3: `srv_valid_o` is high while any queue is non-empty. `srv_ch_o` names the lowest-numbered non-empty channel. `srv_ready_i` removes one entry from that channel in the same cycle.
- R4: Identifier 0, mode 00, size not 101 or 110 sets `ch0_req_o` on the next clock edge. This happens only when `ch0_en_o` is high and `ch0_busy_i` is low; otherwise the command is ignored. `ch0_ack_i` clears `ch0_req_o`.
- R5: Identifier 0, mode not 00, size 111 clears `ch0_en_o`. This stop is refused while `ch0_edge_burst_i` and `ch0_busy_i` are both high.
- R6: After a stop, only `ch0_en_set_i` sets `ch0_en_o` again. No command can restart it.
- R7: Identifier 0, mode 10, size 110 clears `ch0_req_o`, empties all three queues and clears `frozen_o`. `freeze_i` sets `frozen_o`.
- R8: Any other identifier-0 encoding changes no state and sets the sticky `illegal_o`.
- R9: After `bus_req_i`, once `arb_idle_i` is high, `grant_o` is high for exactly one cycle when `row_miss_i` is low.
- R10: When `row_miss_i` is high at grant start, `grant_o` stays high for `tcp_i` cycles, or 1 cycle if `tcp_i` is 0.
- R11: A `bus_req_i` arriving while an earlier request awaits its grant sets the sticky `proto_err_o` and produces no extra grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_i | input | 7 | Command word {id, mode, size} |
| ch0_busy_i | input | 1 | Channel-0 bus cycle / transfer in progress |
| ch0_edge_burst_i | input | 1 | Channel 0 set for edge-detect burst mode |
| ch0_en_set_i | input | 1 | Register write setting the channel-0 enable |
| ch0_ack_i | input | 1 | Channel-0 request consumed |
| freeze_i | input | 1 | Enter frozen state |
| srv_ready_i | input | 1 | Downstream takes the offered queued request |
| bus_req_i | input | 1 | Device bus request pulse |
| arb_idle_i | input | 1 | Arbiter can grant |
| row_miss_i | input | 1 | Access needs precharge |
| tcp_i | input | TCPW | Precharge interval in cycles |
| ch0_en_o | output | 1 | Channel-0 enable |
| ch0_req_o | output | 1 | Channel-0 handshake request pending |
| frozen_o | output | 1 | Frozen state |
| illegal_o | output | 1 | Sticky illegal-command flag |
| q_full_o | output | 3 | Queue full per channel 1..3 |
| srv_valid_o | output | 1 | A queued request is offered |
| srv_ch_o | output | 2 | Channel of the offered request |
| grant_o | output | 1 | Bus grant |
| proto_err_o | output | 1 | Sticky double-request flag |

## Verification
A queue counter that is off by one shows up at the service port. The number of `srv_valid_o` cycles seen while draining no longer matches the number of accepted pushes, and `q_full_o` rises one push early or late. A misrouted identifier appears as the wrong `srv_ch_o` on the first pop. Errors in the channel-0 enable or pending state are visible on `ch0_en_o` and `ch0_req_o` one edge after the command. A wrong grant counter or a lost outstanding request changes the length of the `grant_o` pulse, or removes it, within a few cycles of `arb_idle_i`.

// File: rtl/dma_cmd_pkg.sv
package dma_cmd_pkg;
  localparam int unsigned CMD_W = 7;

  typedef struct packed {
    logic [1:0] id;
    logic [1:0] md;
    logic [2:0] sz;
  } cmd_t;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_HS,
    ACT_END,
    ACT_CLR,
    ACT_QUEUE,
    ACT_BAD
  } act_e;
endpackage

// File: rtl/dma_cmd_decode.sv
module dma_cmd_decode
  import dma_cmd_pkg::*;
(
  input  logic             valid_i,
  input  logic [CMD_W-1:0] cmd_i,
  output act_e             act_o,
  output logic [1:0]       ch_o
);
  cmd_t c;
  assign c    = cmd_t'(cmd_i);
  assign ch_o = c.id;

  always_comb begin
    act_o = ACT_NONE;
    if (valid_i) begin
      if (c.id != 2'b00)                                  act_o = ACT_QUEUE;
      else if (c.md == 2'b00 && c.sz != 3'b101 && c.sz != 3'b110) act_o = ACT_HS;
      else if (c.md == 2'b10 && c.sz == 3'b110)           act_o = ACT_CLR;
      else if (c.md != 2'b00 && c.sz == 3'b111)           act_o = ACT_END;
      else                                                act_o = ACT_BAD;
    end
  end
endmodule

// File: rtl/dma_req_queue.sv
module dma_req_queue #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          flush_i,
  output logic          full_o,
  output logic          nonempty_o
);
  logic [CW-1:0] cnt_q;

  assign full_o     = (cnt_q == CW'(DEPTH));
  assign nonempty_o = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (flush_i)     cnt_q <= '0;
    else begin
      case ({push_i && !full_o, pop_i && nonempty_o})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  a_r2_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  a_r2_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && push_i && !pop_i && !flush_i |=> full_o);
  a_r7_flush_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !nonempty_o);
endmodule

// File: rtl/dma_grant_ctl.sv
module dma_grant_ctl #(
  parameter int unsigned TCPW = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bus_req_i,
  input  logic            arb_idle_i,
  input  logic            row_miss_i,
  input  logic [TCPW-1:0] tcp_i,
  output logic            grant_o,
  output logic            proto_err_o
);
  logic            pend_q, err_q;
  logic [TCPW-1:0] gcnt_q, len;
  logic            start;

  assign grant_o     = (gcnt_q != '0);
  assign proto_err_o = err_q;
  assign start       = pend_q && arb_idle_i && !grant_o;
  assign len         = (row_miss_i && tcp_i != '0) ? tcp_i : TCPW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      err_q  <= 1'b0;
      gcnt_q <= '0;
    end else begin
      if (bus_req_i && pend_q) err_q <= 1'b1;
      if (start)               pend_q <= 1'b0;
      else if (bus_req_i)      pend_q <= 1'b1;
      if (start)               gcnt_q <= len;
      else if (grant_o)        gcnt_q <= gcnt_q - 1'b1;
    end
  end

  a_r9_single_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start && !row_miss_i |=> grant_o ##1 !grant_o);
  a_r11_sticky_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |=> proto_err_o);
  a_r11_err_on_double: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && bus_req_i |=> proto_err_o);
endmodule

// File: rtl/dma_cmd_front.sv
module dma_cmd_front
  import dma_cmd_pkg::*;
#(
  parameter int unsigned QDEPTH = 4,
  parameter int unsigned TCPW   = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cmd_valid_i,
  input  logic [6:0]      cmd_i,
  input  logic            ch0_busy_i,
  input  logic            ch0_edge_burst_i,
  input  logic            ch0_en_set_i,
  input  logic            ch0_ack_i,
  input  logic            freeze_i,
  input  logic            srv_ready_i,
  input  logic            bus_req_i,
  input  logic            arb_idle_i,
  input  logic            row_miss_i,
  input  logic [TCPW-1:0] tcp_i,
  output logic            ch0_en_o,
  output logic            ch0_req_o,
  output logic            frozen_o,
  output logic            illegal_o,
  output logic [2:0]      q_full_o,
  output logic            srv_valid_o,
  output logic [1:0]      srv_ch_o,
  output logic            grant_o,
  output logic            proto_err_o
);
  localparam int unsigned NQ = 3;

  act_e       act;
  logic [1:0] cmd_ch;
  logic [NQ-1:0] nonempty;
  logic en_q, req_q, frz_q, bad_q;
  logic hs_ok, end_ok;

  dma_cmd_decode u_dec (
    .valid_i (cmd_valid_i),
    .cmd_i   (cmd_i),
    .act_o   (act),
    .ch_o    (cmd_ch)
  );

  for (genvar g = 0; g < NQ; g++) begin : g_q
    dma_req_queue #(.DEPTH(QDEPTH)) u_q (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .push_i     (act == ACT_QUEUE && cmd_ch == 2'(g + 1)),
      .pop_i      (srv_ready_i && srv_valid_o && srv_ch_o == 2'(g + 1)),
      .flush_i    (act == ACT_CLR),
      .full_o     (q_full_o[g]),
      .nonempty_o (nonempty[g])
    );
  end

  always_comb begin
    srv_ch_o = 2'd0;
    for (int i = NQ - 1; i >= 0; i--)
      if (nonempty[i]) srv_ch_o = 2'(i + 1);
  end
  assign srv_valid_o = |nonempty;

  assign hs_ok  = (act == ACT_HS) && en_q && !ch0_busy_i;
  assign end_ok = (act == ACT_END) && !(ch0_edge_burst_i && ch0_busy_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      req_q <= 1'b0;
      frz_q <= 1'b0;
      bad_q <= 1'b0;
    end else begin
      if (end_ok)            en_q <= 1'b0;
      else if (ch0_en_set_i) en_q <= 1'b1;
      if (act == ACT_CLR)    req_q <= 1'b0;
      else if (hs_ok)        req_q <= 1'b1;
      else if (ch0_ack_i)    req_q <= 1'b0;
      if (act == ACT_CLR)    frz_q <= 1'b0;
      else if (freeze_i)     frz_q <= 1'b1;
      if (act == ACT_BAD)    bad_q <= 1'b1;
    end
  end

  assign ch0_en_o  = en_q;
  assign ch0_req_o = req_q;
  assign frozen_o  = frz_q;
  assign illegal_o = bad_q;

  dma_grant_ctl #(.TCPW(TCPW)) u_gnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_req_i   (bus_req_i),
    .arb_idle_i  (arb_idle_i),
    .row_miss_i  (row_miss_i),
    .tcp_i       (tcp_i),
    .grant_o     (grant_o),
    .proto_err_o (proto_err_o)
  );

  a_r4_busy_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ch0_req_o && ch0_busy_i && !ch0_ack_i |=> !ch0_req_o);
  a_r6_no_cmd_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ch0_en_o && !ch0_en_set_i |=> !ch0_en_o);
  a_r5_end_refused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ch0_en_o && ch0_edge_burst_i && ch0_busy_i |=> ch0_en_o);
  a_r3_srv_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srv_valid_o |-> srv_ch_o != 2'd0);
endmodule

// File: tb/dma_cmd_front_test.sv
module dma_cmd_front_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0; logic [6:0] cmd = '0;
  logic busy = 0, edge_burst = 0, en_set = 0, ack = 0, freeze = 0, srv_ready = 0;
  logic bus_req = 0, arb_idle = 0, row_miss = 0; logic [3:0] tcp = '0;
  logic en, req, frozen, illegal, srv_valid, grant, perr;
  logic [2:0] qfull; logic [1:0] srv_ch;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  dma_cmd_front uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .ch0_busy_i(busy), .ch0_edge_burst_i(edge_burst), .ch0_en_set_i(en_set),
    .ch0_ack_i(ack), .freeze_i(freeze), .srv_ready_i(srv_ready),
    .bus_req_i(bus_req), .arb_idle_i(arb_idle), .row_miss_i(row_miss), .tcp_i(tcp),
    .ch0_en_o(en), .ch0_req_o(req), .frozen_o(frozen), .illegal_o(illegal),
    .q_full_o(qfull), .srv_valid_o(srv_valid), .srv_ch_o(srv_ch),
    .grant_o(grant), .proto_err_o(perr));

  task automatic check(string r, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic send(logic [1:0] id, logic [1:0] md, logic [2:0] sz);
    @(negedge clk); cmd_valid = 1; cmd = {id, md, sz};
    @(negedge clk); cmd_valid = 0;
  endtask

  task automatic pulse_en_set();
    @(negedge clk); en_set = 1; @(negedge clk); en_set = 0;
  endtask

  // pops everything, returns channel sequence packed 2 bits per pop
  task automatic drain(output int n, output logic [31:0] seq);
    n = 0; seq = '0;
    @(negedge clk);
    while (srv_valid && n < 16) begin
      seq = {seq[29:0], srv_ch}; n++;
      srv_ready = 1; @(negedge clk); srv_ready = 0;
    end
  endtask

  task automatic t_reset();
    check("R4 reset req", int'(req), 0);
    check("R2 reset full", int'(qfull), 0);
    check("R3 reset valid", int'(srv_valid), 0);
    check("R8 reset illegal", int'(illegal), 0);
    check("R11 reset perr", int'(perr), 0);
    check("R9 reset grant", int'(grant), 0);
  endtask

  task automatic t_queue();
    int n; logic [31:0] s;
    send(2'd2, 2'b11, 3'b110); // R1 mode/size ignored
    send(2'd3, 2'b00, 3'b000);
    send(2'd2, 2'b10, 3'b111);
    send(2'd1, 2'b01, 3'b101);
    check("R3 lowest channel offered", int'(srv_ch), 1);
    drain(n, s);
    check("R1 pop count", n, 4);
    check("R3 order", int'(s[7:0]), 8'b01_10_10_11);
    for (int i = 0; i < 6; i++) send(2'd3, 2'b00, 3'b000);
    check("R2 ch3 full", int'(qfull), 3'b100);
    drain(n, s);
    check("R2 depth kept", n, 4);
  endtask

  task automatic t_ch0();
    send(2'd0, 2'b00, 3'b001);
    check("R4 ignored when disabled", int'(req), 0);
    pulse_en_set();
    check("R6 enable write", int'(en), 1);
    busy = 1; send(2'd0, 2'b00, 3'b111); busy = 0;
    check("R4 ignored when busy", int'(req), 0);
    send(2'd0, 2'b00, 3'b100);
    check("R4 handshake", int'(req), 1);
    @(negedge clk); ack = 1; @(negedge clk); ack = 0;
    check("R4 ack clears", int'(req), 0);
    busy = 1; edge_burst = 1; send(2'd0, 2'b01, 3'b111);
    check("R5 end refused in burst", int'(en), 1);
    busy = 0; edge_burst = 0;
    send(2'd0, 2'b11, 3'b111);
    check("R5 end clears enable", int'(en), 0);
    send(2'd0, 2'b00, 3'b000);
    check("R6 no restart by command", int'(req), 0);
    check("R6 still disabled", int'(en), 0);
    pulse_en_set();
    check("R6 restart by write", int'(en), 1);
  endtask

  task automatic t_clear_illegal();
    int n; logic [31:0] s;
    send(2'd0, 2'b00, 3'b010);
    send(2'd1, 2'b00, 3'b000);
    send(2'd2, 2'b00, 3'b000);
    @(negedge clk); freeze = 1; @(negedge clk); freeze = 0;
    check("R7 frozen set", int'(frozen), 1);
    send(2'd0, 2'b01, 3'b110);
    check("R8 illegal flag", int'(illegal), 1);
    check("R8 no effect on req", int'(req), 1);
    check("R8 no effect on queues", int'(srv_ch), 1);
    send(2'd0, 2'b10, 3'b110);
    check("R7 req cleared", int'(req), 0);
    check("R7 unfrozen", int'(frozen), 0);
    drain(n, s);
    check("R7 queues empty", n, 0);
  endtask

  task automatic count_grant(output int n);
    n = 0;
    for (int i = 0; i < 24; i++) begin @(negedge clk); if (grant) n++; end
  endtask

  task automatic t_grant();
    int n;
    @(negedge clk); bus_req = 1; @(negedge clk); bus_req = 0;
    check("R9 no grant while busy arbiter", int'(grant), 0);
    arb_idle = 1; count_grant(n);
    check("R9 one grant cycle", n, 1);
    row_miss = 1; tcp = 4'd5;
    @(negedge clk); bus_req = 1; @(negedge clk); bus_req = 0;
    count_grant(n);
    check("R10 precharge grant length", n, 5);
    tcp = 4'd0;
    @(negedge clk); bus_req = 1; @(negedge clk); bus_req = 0;
    count_grant(n);
    check("R10 zero interval", n, 1);
    row_miss = 0; arb_idle = 0;
    check("R11 no err yet", int'(perr), 0);
    @(negedge clk); bus_req = 1; @(negedge clk); @(negedge clk); bus_req = 0;
    check("R11 double request flagged", int'(perr), 1);
    arb_idle = 1; count_grant(n);
    check("R11 single grant", n, 1);
    check("R11 sticky", int'(perr), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_queue();
    t_ch0();
    t_clear_illegal();
    t_grant();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule